// File: doc/BRIEF.md
# Mode and Sync Control Register

This block is an 8-bit control register that a host writes to choose how the receive datapath runs. It holds the datapath in soft reset, picks one of three input modes, and chooses whether this device drives the shared sync lines or listens to them. After reset the register holds the datapath in soft reset as a sync slave. Several devices can therefore share sync wiring with no driver contention until the host assigns one of them as master.

The low three bits select the mode. Bit 0 is the soft-reset hold. Bits 2 and 1 pick the mode once bit 0 is cleared. Bit 3 picks the sync direction. The upper nibble is reserved: it is not stored and always reads back as zero. Bits 2 and 1 both set, with bit 0 clear, is not a legal mode. That pattern raises an error flag and keeps the datapath idle. Every decoded output comes straight from the stored bits, so each one follows a write on the next clock edge.

Top module: `mode_sync_ctl`

## Requirements
- R1: After reset the readback is 0x01, soft reset is asserted, all sync output enables are low, and no mode flag or run enable is set.
- R2: While stored bit 0 is 1, soft reset is high and the run enable and all four mode flags (three modes plus error) are low, whatever bits 2 and 1 hold.
- R3: With stored bits 2..0 equal to 000, only the single-channel real flag is set and the run enable is high.
- R4: With stored bits 2..0 equal to 010, only the dual-channel real flag is set and the run enable is high.
- R5: With stored bits 2..0 equal to 100, only the single-channel complex flag is set and the run enable is high.
- R6: With stored bits 2..0 equal to 110, the mode-error flag is set, the three mode flags are low, and the run enable is low.
- R7: Stored bit 3 set to 1 drives every sync output enable high (master). Set to 0, it drives every enable low (slave). This holds whatever the mode bits are.
- R8: Readback returns the stored bits 3..0 in place, and bits 7..4 always read as 0.
- R9: A write with the write enable low has no effect: the readback and all decoded outputs keep their values.
- R10: When soft reset is low, exactly one of the four flags (three modes plus error) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Readback of stored bits, reserved bits zero |
| soft_rst | output | 1 | Holds the datapath in soft reset |
| run_en | output | 1 | Datapath may run (no soft reset, legal mode) |
| mode_sreal | output | 1 | Single-channel real mode |
| mode_dreal | output | 1 | Dual-channel real mode |
| mode_cplx | output | 1 | Single-channel complex mode |
| mode_err | output | 1 | Illegal mode bit combination |
| sync_master | output | 1 | Device is sync master |
| sync_oe | output | SYNC_W | Output enables for the bidirectional sync pins |

## Verification
The assertions check four things on every cycle. The mode flags stay mutually exclusive and complete outside soft reset. Soft reset and the error case keep the datapath idle. The sync enables agree with the readback master bit. Reserved readback bits are zero and the register holds while not written. Only the bench scenarios can show that each particular bit pattern decodes to the right named mode. They also show that reserved write bits are dropped rather than stored, and that a reset in mid-run brings back the slave, soft-reset state.

// File: rtl/mode_sync_ctl.sv
module mode_sync_ctl #(
  parameter int SYNC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              soft_rst,
  output logic              run_en,
  output logic              mode_sreal,
  output logic              mode_dreal,
  output logic              mode_cplx,
  output logic              mode_err,
  output logic              sync_master,
  output logic [SYNC_W-1:0] sync_oe
);
  localparam logic [3:0] CTL_RST = 4'b0001;

  logic [3:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= CTL_RST;
    else if (wr_en) ctl_q <= wr_data[3:0];
  end

  assign rd_data     = {4'b0000, ctl_q};
  assign soft_rst    = ctl_q[0];
  assign mode_sreal  = (ctl_q[2:0] == 3'b000);
  assign mode_dreal  = (ctl_q[2:0] == 3'b010);
  assign mode_cplx   = (ctl_q[2:0] == 3'b100);
  assign mode_err    = (ctl_q[2:0] == 3'b110);
  assign run_en      = mode_sreal | mode_dreal | mode_cplx;
  assign sync_master = ctl_q[3];
  assign sync_oe     = {SYNC_W{ctl_q[3]}};
endmodule

module mode_sync_ctl_chk #(
  parameter int SYNC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              soft_rst,
  input logic              run_en,
  input logic              mode_sreal,
  input logic              mode_dreal,
  input logic              mode_cplx,
  input logic              mode_err,
  input logic              sync_master,
  input logic [SYNC_W-1:0] sync_oe
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == 8'h01 && soft_rst && sync_oe == '0));

  a_r2_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !run_en && !mode_sreal && !mode_dreal && !mode_cplx && !mode_err);

  a_r3_sreal_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2:0] == 3'b000) |=> mode_sreal && run_en);

  a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !run_en);

  a_r7_sync_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_oe == {SYNC_W{rd_data[3]}}) && (sync_master == rd_data[3]));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:4] == 4'h0);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  a_r10_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |-> $countones({mode_sreal, mode_dreal, mode_cplx, mode_err}) == 1);
endmodule

bind mode_sync_ctl mode_sync_ctl_chk #(.SYNC_W(SYNC_W)) u_chk (.*);

// File: tb/test_mode_sync_ctl.sv
module test_mode_sync_ctl;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic soft_rst, run_en, mode_sreal, mode_dreal, mode_cplx, mode_err, sync_master;
  logic [SW-1:0] sync_oe;

  int checks = 0;
  int errors = 0;
  logic [3:0] model = 4'b0001;

  always #4 clk = ~clk;

  mode_sync_ctl #(.SYNC_W(SW)) i_mode_sync_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .soft_rst(soft_rst), .run_en(run_en),
    .mode_sreal(mode_sreal), .mode_dreal(mode_dreal), .mode_cplx(mode_cplx),
    .mode_err(mode_err), .sync_master(sync_master), .sync_oe(sync_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_mode(input logic [3:0] m, input logic [2:0] pat);
    return m[2:0] == pat;
  endfunction

  task automatic check_all(input string tag);
    logic run;
    run = exp_mode(model, 3'b000) | exp_mode(model, 3'b010) | exp_mode(model, 3'b100);
    chk({tag, " R8 readback"}, 32'(rd_data), 32'({4'h0, model}));
    chk({tag, " R2 soft reset"}, 32'(soft_rst), 32'(model[0]));
    chk({tag, " R2 run enable"}, 32'(run_en), 32'(run));
    chk({tag, " R3 single real"}, 32'(mode_sreal), 32'(exp_mode(model, 3'b000)));
    chk({tag, " R4 dual real"}, 32'(mode_dreal), 32'(exp_mode(model, 3'b010)));
    chk({tag, " R5 complex"}, 32'(mode_cplx), 32'(exp_mode(model, 3'b100)));
    chk({tag, " R6 mode error"}, 32'(mode_err), 32'(exp_mode(model, 3'b110)));
    chk({tag, " R7 sync master"}, 32'(sync_master), 32'(model[3]));
    chk({tag, " R7 sync oe"}, 32'(sync_oe), 32'({SW{model[3]}}));
    if (!soft_rst)
      chk({tag, " R10 one flag"}, 32'($countones({mode_sreal, mode_dreal, mode_cplx, mode_err})), 32'd1);
  endtask

  task automatic write_reg(input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model = d[3:0];
    check_all(tag);
  endtask

  task automatic idle_cycle(input logic [7:0] junk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = junk;
    @(negedge clk);
    check_all("R9 hold");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    write_reg(8'h00, "R3");
    write_reg(8'h02, "R4");
    write_reg(8'h04, "R5");
    write_reg(8'h06, "R6");
    write_reg(8'h07, "R2 err bits with reset");
    write_reg(8'h03, "R2");
    write_reg(8'h08, "R7 master sreal");
    write_reg(8'h0E, "R7 master err");
    write_reg(8'hF2, "R8 reserved dropped");
    write_reg(8'hFF, "R8 all ones");
    idle_cycle(8'h00);
    idle_cycle(8'h04);

    for (int i = 0; i < 300; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if ($urandom % 4 == 0) idle_cycle(d);
      else write_reg(d, "rand");
    end

    write_reg(8'h0C, "R7 master complex");
    @(negedge clk);
    rst_n = 1'b0;
    model = 4'b0001;
    @(negedge clk);
    check_all("R1 mid-run reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 released");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule